// File: doc/BRIEF.md
# I2C Master Byte Engine with Software Handshake

This block is a bus master for a two-wire serial bus, steered by software one byte at a time through four 8-bit registers. Software loads a byte into the data register and then writes the status register with a mode and a START request. The engine then produces a START condition and shifts that byte out as the address. At the end of every byte it raises a pending flag and holds SCL low. Software then inspects the acknowledge result or reads the received byte, queues the next action, and clears the flag to let the bus move on.

The SCL rate comes from the system clock. A selectable prescaler (16 or 512) is followed by a divisor of (d + 1), with d a 4-bit field. Each bit lasts four quarter-periods: two with SCL low, during which SDA changes one quarter after the falling edge, and two with SCL high. The block supports master transmit and master receive. In receive it either drives or withholds the acknowledge. A repeated START is queued by writing the status register with START set while the bus is owned, and a STOP is queued by writing it with START clear. Both take effect when the pending flag is cleared. Both bus lines are open-drain: an output of 1 pulls the line low.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, all four registers read 0x00, both open-drain enables are 0 (lines released) and `irq` is 0. Register select codes are 0 control, 1 status, 2 own address, 3 data.
- R2: The SCL period is P*(d+1) system clocks and SCL is high for half of it. P is 16 when control bit 6 is 0 and 512 when it is 1, and d is control bits 3:0.
- R3: A status write with bit 7 = 1 (master mode), bit 5 = 1 (START) and bit 4 = 1 (enable) while the bus is idle produces SDA falling while SCL is high, sets status bit 5 (busy), then shifts the data register out MSB first.
- R4: After the ninth clock of every byte, control bit 4 (pending) is set, 38 quarter-periods after the START write for the address byte, and SCL stays low while it is set. Writing control bit 4 as 0 releases the bus. Writing it as 1 leaves it unchanged.
- R5: Status bit 0 holds the SDA level sampled in the ninth clock of the most recent transmitted byte: 1 = NACK, 0 = ACK.
- R6: In master transmit mode (status bits 7:6 = 11), clearing pending shifts out the current data register MSB first.
- R7: In master receive mode (status bits 7:6 = 10), bytes after the address byte are sampled MSB first and are readable in the data register once pending is set. In the ninth clock SDA is driven low when control bit 7 is 1 and released when it is 0.
- R8: A status write with bit 5 = 0 while busy, followed by clearing pending, produces SDA rising while SCL is high. Busy then reads 0 with both lines released.
- R9: A status write with bits 7, 5 and 4 set while busy, followed by clearing pending, produces a repeated START and then shifts the data register out as an address byte.
- R10: `irq` is 1 exactly when pending and control bit 5 (interrupt enable) are both 1.
- R11: A START request is ignored when status bit 7 or bit 4 of the written value is 0. The bus stays released and busy stays 0, although the mode and enable bits are stored.
- R12: The own-address register stores and returns any 8-bit value and has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 own address, 3 data |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
With the divisor at 0 and the small prescaler, a quarter-period is 4 clocks. The address byte's pending flag is therefore due 38 quarters (152 clocks) after the clock edge that takes the START write. The bench samples `irq` at 140 clocks, where it must still be low, and at 160 clocks, where it must be high. Received bytes, acknowledge results and STOP completion are due only after pending or idle is observed, so those checks poll the register interface and compare only after that point. SCL timing is measured as whole clock counts between line edges in the first address bit, where the quarter counter runs unbroken.

// File: rtl/i2cbe_pkg.sv
// Shared types of the I2C byte engine: register selects, queued commands,
// engine states and the control register layout.
package i2cbe_pkg;
    localparam int DIV_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_OWN  = 2'd2,
        SEL_DATA = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        CMD_NEXT    = 2'd0,
        CMD_STOP    = 2'd1,
        CMD_RESTART = 2'd2
    } cmd_e;

    typedef enum logic [3:0] {
        E_IDLE, E_SETUP, E_RISE, E_STA, E_BIT, E_HOLD, E_P0, E_P1, E_P2
    } eng_e;

    typedef struct packed {
        logic             ack_gen;
        logic             pre_sel;
        logic             irq_en;
        logic             pend;
        logic [DIV_W-1:0] div;
    } ctrl_t;
endpackage

// File: rtl/i2cbe_clkgen.sv
// Quarter-period tick generator.
// Emits one tick every (PRE/4)*(div+1) clocks while run is high. The count
// restarts whenever run is low, so every action starts with a whole quarter.
// Assumes PRE_LO and PRE_HI are multiples of 4 and at least 8.
module i2cbe_clkgen #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int QLO = PRE_LO / 4;
    localparam int QHI = PRE_HI / 4;
    localparam int CW  = $clog2(QHI * (2 ** DIV_W)) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Quarter length minus one for the selected prescaler and divisor.
    always_comb limit = CW'((pre_sel ? QHI : QLO) * (int'(div) + 1) - 1);

    assign tick = run && (cnt >= limit);

    // Count clocks inside the quarter; restart on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R2: quarters are never shorter than two clocks.
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/i2cbe_engine.sv
// Bit-level bus sequencer.
// Produces START, repeated START, data bytes (transmit or receive, with the
// ninth acknowledge clock) and STOP. Each bit is four quarters: q0 and q1
// with SCL low (SDA updated at the end of q0), q2 and q3 with SCL high
// (SDA sampled as SCL rises). After each byte it parks in HOLD with SCL low
// until next_go arrives. The first byte after any START is always sent.
module i2cbe_engine
    import i2cbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_go,
    input  logic              next_go,
    input  cmd_e              cmd,
    input  logic              mode_rx,
    input  logic              ack_gen,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_i,
    output logic              run,
    output logic              busy,
    output logic              scl_low,
    output logic              sda_low,
    output logic              byte_done,
    output logic              done_was_tx,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_sample
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(BYTE_W);

    eng_e              state;
    logic [1:0]        q;
    logic [BCW-1:0]    bit_cnt;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_sh;
    logic              is_tx;
    logic              sda_r;
    logic              ack_s;

    // Main sequencer: state, quarter, bit count, shifters and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= E_IDLE;
            q       <= 2'd0;
            bit_cnt <= '0;
            tx_q    <= '0;
            rx_sh   <= '0;
            is_tx   <= 1'b1;
            sda_r   <= 1'b0;
            ack_s   <= 1'b0;
        end else begin
            case (state)
                E_IDLE: if (start_go) begin
                    state <= E_RISE;
                    sda_r <= 1'b0;
                end
                E_SETUP: if (tick) state <= E_RISE;
                E_RISE: if (tick) begin
                    state <= E_STA;
                    sda_r <= 1'b1;
                end
                E_STA: if (tick) begin
                    state   <= E_BIT;
                    q       <= 2'd0;
                    bit_cnt <= '0;
                    tx_q    <= tx_byte;
                    is_tx   <= 1'b1;
                end
                E_BIT: if (tick) begin
                    q <= q + 2'd1;
                    case (q)
                        2'd0: begin
                            if (bit_cnt == ACK_SLOT) sda_r <= is_tx ? 1'b0 : ack_gen;
                            else                     sda_r <= is_tx ? !tx_q[BYTE_W-1] : 1'b0;
                        end
                        2'd1: begin
                            if (bit_cnt == ACK_SLOT) ack_s <= sda_i;
                            else                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
                        end
                        2'd3: begin
                            if (bit_cnt == ACK_SLOT) state <= E_HOLD;
                            else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                tx_q    <= tx_q << 1;
                            end
                        end
                        default: ;
                    endcase
                end
                E_HOLD: if (next_go) begin
                    case (cmd)
                        CMD_STOP: begin
                            state <= E_P0;
                            sda_r <= 1'b1;
                        end
                        CMD_RESTART: begin
                            state <= E_SETUP;
                            sda_r <= 1'b0;
                        end
                        default: begin
                            state   <= E_BIT;
                            q       <= 2'd0;
                            bit_cnt <= '0;
                            tx_q    <= tx_byte;
                            is_tx   <= !mode_rx;
                        end
                    endcase
                end
                E_P0: if (tick) state <= E_P1;
                E_P1: if (tick) begin
                    state <= E_P2;
                    sda_r <= 1'b0;
                end
                E_P2: if (tick) state <= E_IDLE;
                default: state <= E_IDLE;
            endcase
        end
    end

    // Line drive and status towards the register block.
    always_comb begin
        scl_low     = (state == E_SETUP) || (state == E_P0) || (state == E_HOLD)
                   || ((state == E_BIT) && !q[1]);
        sda_low     = sda_r;
        busy        = (state != E_IDLE);
        run         = (state != E_IDLE) && (state != E_HOLD);
        byte_done   = tick && (state == E_BIT) && (q == 2'd3) && (bit_cnt == ACK_SLOT);
        done_was_tx = is_tx;
        rx_byte     = rx_sh;
        ack_sample  = ack_s;
    end

    // R6: SDA never changes while SCL is high inside a bit.
    p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == E_BIT) && q[1] && $past((state == E_BIT) && q[1])) |-> $stable(sda_r));
    // R3: SDA may only be pulled low under a high SCL when forming START.
    p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_r) && !scl_low) |-> (state == E_STA));
    // R8: leaving the busy state happens with both lines released.
    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!sda_low && !scl_low));
endmodule

// File: rtl/i2c_byte_master.sv
// Register block and top level of the I2C byte engine.
// Holds control, status, own-address and data registers. It turns status
// writes into START or queued STOP / repeated START requests, and keeps the
// pending flag that stalls the bus between bytes. Assumes a single-cycle
// write strobe and a combinational read.
module i2c_byte_master
    import i2cbe_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    ctrl_t             ctrl_q;
    logic [1:0]        mode_q;
    logic              en_q;
    logic              nack_q;
    logic [BYTE_W-1:0] own_q;
    logic [BYTE_W-1:0] data_q;
    cmd_e              cmd_q;

    sel_e              sel;
    logic              wr_ctrl, wr_stat, wr_own, wr_data;
    logic              master_start, start_go, next_go;
    logic              tick, run, busy, scl_low, sda_low;
    logic              byte_done, done_was_tx, ack_sample;
    logic [BYTE_W-1:0] rx_byte;

    // Decode the register write strobe and the engine triggers.
    always_comb begin
        sel          = sel_e'(reg_sel);
        wr_ctrl      = reg_we && (sel == SEL_CTRL);
        wr_stat      = reg_we && (sel == SEL_STAT);
        wr_own       = reg_we && (sel == SEL_OWN);
        wr_data      = reg_we && (sel == SEL_DATA);
        master_start = reg_wdata[7] && reg_wdata[5] && reg_wdata[4];
        start_go     = wr_stat && master_start && !busy;
        next_go      = wr_ctrl && ctrl_q.pend && !reg_wdata[4];
    end

    // Control register; pending is set by the engine and only cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else begin
            if (wr_ctrl) begin
                ctrl_q.ack_gen <= reg_wdata[7];
                ctrl_q.pre_sel <= reg_wdata[6];
                ctrl_q.irq_en  <= reg_wdata[5];
                ctrl_q.div     <= reg_wdata[DIV_W-1:0];
                if (!reg_wdata[4]) ctrl_q.pend <= 1'b0;
            end
            if (byte_done) ctrl_q.pend <= 1'b1;
        end
    end

    // Status fields and the command queued for the next pending release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            en_q   <= 1'b0;
            nack_q <= 1'b0;
            cmd_q  <= CMD_NEXT;
        end else begin
            if (wr_stat) begin
                mode_q <= reg_wdata[7:6];
                en_q   <= reg_wdata[4];
            end
            if (start_go || next_go)             cmd_q <= CMD_NEXT;
            else if (wr_stat && busy) begin
                if (master_start)                cmd_q <= CMD_RESTART;
                else if (!reg_wdata[5])          cmd_q <= CMD_STOP;
            end
            if (byte_done && done_was_tx)        nack_q <= ack_sample;
        end
    end

    // Own-address and data registers; received bytes land in data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_own) own_q <= reg_wdata;
            if (byte_done && !done_was_tx) data_q <= rx_byte;
            else if (wr_data)              data_q <= reg_wdata;
        end
    end

    // Read mux over the four registers.
    always_comb begin
        case (sel)
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_STAT: reg_rdata = {mode_q, busy, en_q, 3'b000, nack_q};
            SEL_OWN:  reg_rdata = own_q;
            default:  reg_rdata = data_q;
        endcase
    end

    assign irq    = ctrl_q.pend && ctrl_q.irq_en;
    assign scl_oe = scl_low;
    assign sda_oe = sda_low;

    i2cbe_clkgen #(
        .PRE_LO (PRE_LO),
        .PRE_HI (PRE_HI),
        .DIV_W  (DIV_W)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pre_sel (ctrl_q.pre_sel),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    i2cbe_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_go    (start_go),
        .next_go     (next_go),
        .cmd         (cmd_q),
        .mode_rx     (mode_q == 2'b10),
        .ack_gen     (ctrl_q.ack_gen),
        .tx_byte     (data_q),
        .sda_i       (sda_i),
        .run         (run),
        .busy        (busy),
        .scl_low     (scl_low),
        .sda_low     (sda_low),
        .byte_done   (byte_done),
        .done_was_tx (done_was_tx),
        .rx_byte     (rx_byte),
        .ack_sample  (ack_sample)
    );

    // R4: the bus is stretched for as long as pending is set.
    p_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.pend |-> scl_oe);
    // R4: pending only rises at the end of a byte.
    p_pend_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.pend) |-> $past(byte_done));
    // R10: an interrupt only occurs while the bus is owned.
    p_irq_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);
endmodule

// File: tb/i2c_byte_master_tb_top.sv
// Directed bench: one task per scenario, a behavioural target at 7-bit
// address 0x50 on the open-drain lines, self-checking through counters.
module i2c_byte_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;

    logic       slv_low = 1'b0;
    wire        scl_w = ~scl_oe;
    wire        sda_w = ~(sda_oe | slv_low);

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;

    i2c_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural target ----------------
    int         bc = 0, nb = 0, rx_n = 0, tx_i = 0, sta_n = 0, sto_n = 0;
    logic       armed = 1'b0, rd_mode = 1'b0, m_ack = 1'b0;
    logic [7:0] sh = 8'h00, cur = 8'h00;
    logic [7:0] rx_log [8];
    logic [7:0] tx_src [4];
    initial begin
        tx_src[0] = 8'h96; tx_src[1] = 8'h5A; tx_src[2] = 8'h00; tx_src[3] = 8'hFF;
        for (int i = 0; i < 8; i++) rx_log[i] = 8'h00;
    end

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        sta_n++; bc = 0; nb = 0; armed = 1'b0; slv_low = 1'b0; rd_mode = 1'b0;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) sto_n++;
    always @(posedge scl_w) if (armed) begin
        if (bc < 8) sh = {sh[6:0], sda_w};
        else if (rd_mode && nb > 0) m_ack = !sda_w;
    end
    always @(negedge scl_w) begin
        if (!armed) armed = 1'b1;
        else if (bc < 7) begin
            bc++;
            if (rd_mode && nb > 0) slv_low = ~cur[7-bc];
        end else if (bc == 7) begin
            bc = 8;
            if (nb == 0 || !rd_mode) begin
                if (nb == 0) rd_mode = sh[0];
                rx_log[rx_n % 8] = sh;
                rx_n++;
                slv_low = (nb == 0) ? (sh[7:1] == 7'h50) : 1'b1;
            end else slv_low = 1'b0;
        end else begin
            bc = 0; nb++; slv_low = 1'b0;
            if (rd_mode && (nb == 1 || m_ack)) begin
                cur = tx_src[tx_i % 4]; tx_i++; slv_low = ~cur[7];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); reg_sel = s; #1 d = reg_rdata;
    endtask

    task automatic wait_pend(input string req);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, v);
            if (v[4]) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd1, v);
            if (!v[5]) return;
        end
        chk(req, 1, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [7:0] v;
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v); chk("R1 register reset", v, 8'h00);
        end
        chk("R1 scl released", scl_oe, 0);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 irq low", irq, 0);
    endtask

    task automatic t_own;
        logic [7:0] v;
        wr(2'd2, 8'hA5);
        repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R12 own address readback", v, 8'hA5);
        chk("R12 bus untouched", {scl_oe, sda_oe}, 2'b00);
    endtask

    task automatic t_ignored_start;
        logic [7:0] v;
        int s0 = sta_n;
        wr(2'd1, 8'h30);
        repeat (30) @(negedge clk);
        rd(2'd1, v); chk("R11 slave mode start ignored", v, 8'h10);
        chk("R11 no line activity", {scl_oe, sda_oe}, 2'b00);
        wr(2'd1, 8'hE0);
        repeat (30) @(negedge clk);
        rd(2'd1, v); chk("R11 disabled start ignored", v, 8'hC0);
        chk("R11 no START seen", sta_n - s0, 0);
    endtask

    task automatic t_write;
        logic [7:0] v;
        int s0 = sta_n, p0 = sto_n;
        rx_n = 0;
        wr(2'd0, 8'hA0);
        wr(2'd3, 8'hA0);
        wr(2'd1, 8'hF0);
        repeat (140) @(negedge clk);
        chk("R4 pending not yet due", irq, 0);
        repeat (20) @(negedge clk);
        chk("R4 pending due after 38 quarters", irq, 1);
        chk("R10 irq with enable", irq, 1);
        rd(2'd1, v); chk("R3 busy set", v[5], 1);
        chk("R5 ack on address", v[0], 0);
        chk("R3 one START", sta_n - s0, 1);
        chk("R3 address shifted", rx_log[0], 8'hA0);
        repeat (100) @(negedge clk);
        chk("R4 clock stretched", scl_oe, 1);
        wr(2'd0, 8'hB0);
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk("R4 writing 1 keeps pending", v[4], 1);
        chk("R4 still stretched", scl_oe, 1);
        wr(2'd0, 8'h90);
        chk("R10 irq off without enable", irq, 0);
        wr(2'd3, 8'h3C);
        wr(2'd0, 8'h80);
        wait_pend("R6 second byte");
        chk("R6 data byte shifted", rx_log[1], 8'h3C);
        wr(2'd3, 8'hC3);
        wr(2'd0, 8'h80);
        wait_pend("R6 third byte");
        chk("R6 data byte shifted", rx_log[2], 8'hC3);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'h80);
        wait_idle("R8 stop");
        chk("R8 one STOP", sto_n - p0, 1);
        chk("R8 lines released", {scl_oe, sda_oe}, 2'b00);
    endtask

    task automatic t_nack;
        logic [7:0] v;
        wr(2'd3, 8'h22);
        wr(2'd1, 8'hF0);
        wait_pend("R5 nack address");
        rd(2'd1, v); chk("R5 nack recorded", v[0], 1);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'h80);
        wait_idle("R8 stop after nack");
    endtask

    task automatic t_read;
        logic [7:0] v;
        int s0 = sta_n, p0 = sto_n;
        rx_n = 0; tx_i = 0;
        wr(2'd3, 8'hA0);
        wr(2'd1, 8'hF0);
        wait_pend("R9 write address");
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h80);
        wait_pend("R9 pointer byte");
        wr(2'd3, 8'hA1);
        wr(2'd1, 8'hB0);
        wr(2'd0, 8'h80);
        wait_pend("R9 repeated start");
        chk("R9 two STARTs", sta_n - s0, 2);
        chk("R9 read address shifted", rx_log[2], 8'hA1);
        rd(2'd1, v); chk("R5 read address acked", v[0], 0);
        wr(2'd0, 8'h80);
        wait_pend("R7 first read byte");
        rd(2'd3, v); chk("R7 first byte", v, 8'h96);
        chk("R7 master ack driven", m_ack, 1);
        wr(2'd0, 8'h00);
        wait_pend("R7 last read byte");
        rd(2'd3, v); chk("R7 last byte", v, 8'h5A);
        chk("R7 master ack withheld", m_ack, 0);
        wr(2'd1, 8'h90);
        wr(2'd0, 8'h00);
        wait_idle("R8 stop after read");
        chk("R8 STOP after read", sto_n - p0, 1);
    endtask

    task automatic t_rate(input logic [7:0] ctrl, input int hi_exp);
        int t0, t1, t2;
        wr(2'd0, ctrl);
        wr(2'd3, 8'hA0);
        wr(2'd1, 8'hF0);
        @(negedge scl_w);
        @(posedge scl_w); t0 = cyc;
        @(negedge scl_w); t1 = cyc;
        @(posedge scl_w); t2 = cyc;
        chk("R2 SCL high time", t1 - t0, hi_exp);
        chk("R2 SCL period", t2 - t0, 2 * hi_exp);
        wait_pend("R2 byte end");
        wr(2'd1, 8'hD0);
        wr(2'd0, ctrl);
        wait_idle("R2 stop");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_own();
        t_ignored_start();
        t_write();
        t_nack();
        t_read();
        t_rate(8'h03, 32);
        t_rate(8'h40, 256);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule